// File: doc/BRIEF.md
# Debug Breakpoint Match Unit

This block watches a processor's activity for debug breakpoints. It holds no address storage of its own. It takes the addresses of a set of debug slots and a 32-bit control word. Each cycle it can evaluate one of three events: a retired instruction address, a data memory access given as address, byte count and write flag, or a port I/O access given as port number, byte count and the address of the following instruction. The control word gives every slot two enable bits, a 2-bit kind and a 2-bit span code. The block compares every slot in parallel and registers the outcome in a single cycle.

The block keeps a status nibble with one bit per slot. Instruction checks always rewrite it. Data checks rewrite it only when an enabled slot matched, and the new value includes matches from slots whose enables are off. Port checks consider enabled slots only. On a port hit the block also issues an instruction-pointer update that carries the next instruction address. Every check raises a debug request pulse only when an enabled slot took part in the match. Reading and writing the debug registers, delivering the exception and any interrupt-shadow delay are handled outside this block.

Top module: `bkpt_match_top`

## Requirements
- R1: Slot i counts as enabled when control bit 2i or control bit 2i+1 is set, or both.
- R2: Slot i's kind sits in control bits [17+4i:16+4i] and its span code in bits [19+4i:18+4i]. The kind codes are 0 = instruction, 1 = data write only, 2 = port I/O, 3 = data read or write.
- R3: Span code 0 covers 1 byte, 1 covers 2 bytes, 2 covers 8 bytes and 3 covers 4 bytes, starting at the slot address.
- R4: An instruction check matches slot i when slot i is kind 0 and its address equals the instruction address exactly, whether or not the slot is enabled. The status nibble is always replaced by the match mask. A request is raised only when an enabled slot matched.
- R5: A data check matches a kind-3 slot, and a kind-1 slot only when the write flag is 1, if the inclusive byte ranges [addr, addr+size-1] and [slot, slot+span-1] overlap.
- R6: A data check replaces the status nibble with the full match mask, disabled matches included, and raises a request only when at least one enabled slot matched. Otherwise the status nibble is left unchanged.
- R7: A port check matches enabled kind-2 slots whose range overlaps [port, port+size-1]. When any slot matches, the status nibble becomes that mask, a request is raised, and an instruction-pointer update pulse carries the supplied next address. When no slot matches, nothing changes.
- R8: Results appear one clock after the check is presented. The hit mask is zero, and the request and update pulses are low, in any cycle that follows a cycle with no check.
- R9: When several checks are presented in the same cycle, only one is evaluated. A port check takes precedence over a data check, and a data check over an instruction check.
- R10: A data or port access with size 0 matches no slot.
- R11: During reset the hit mask, status nibble, request and update pulse are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWord | input | 32 | Enable, kind and span fields for all slots |
| slotAddrFlat | input | 128 | Slot addresses, slot 0 in the low 32 bits |
| insnValid | input | 1 | Instruction check this cycle |
| insnAddr | input | 32 | Retired instruction address |
| dataValid | input | 1 | Data access check this cycle |
| dataAddr | input | 32 | First byte of the data access |
| dataSize | input | 4 | Data access byte count |
| dataWrite | input | 1 | 1 for a write access |
| portValid | input | 1 | Port access check this cycle |
| portAddr | input | 16 | First port of the access |
| portSize | input | 4 | Port access byte count |
| portNextIp | input | 32 | Address of the instruction after the port access |
| hitMask | output | 4 | Slots matched by the last check |
| statusNibble | output | 4 | Per-slot hit status |
| dbgReq | output | 1 | Debug exception request pulse |
| ipUpdValid | output | 1 | Instruction-pointer update pulse (port hit) |
| ipUpdValue | output | 32 | New instruction address, valid with ipUpdValid |

## Verification
Every result (hit mask, status nibble, request, update pulse and update value) is due on the first rising edge after the check is presented. The bench drives each check on a falling edge and samples all outputs on the next falling edge, half a cycle after that rising edge. It then withdraws the stimulus, so each idle cycle between checks shows the cleared pulses and a held status nibble. The bench computes the expected masks from the span, overlap and enable rules. It sweeps addresses across every boundary of each span code, access size and enable combination.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

  // Slot kind codes carried in the control word
  typedef enum logic [1:0] {
    KIND_INSN   = 2'd0,
    KIND_WRITE  = 2'd1,
    KIND_PORT   = 2'd2,
    KIND_ACCESS = 2'd3
  } slotKind_e;

  // Which check the control selected this cycle
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_INSN = 2'd1,
    SRC_DATA = 2'd2,
    SRC_PORT = 2'd3
  } checkSrc_e;

  // Strobes passed from control to datapath
  typedef struct packed {
    checkSrc_e src;
    logic      writeStatus;
    logic      raise;
    logic      advanceIp;
  } ctrlStrobe_t;

  // Control word layout
  localparam int TYPE_BASE    = 16;
  localparam int LEN_OFS      = 2;
  localparam int FIELD_STRIDE = 4;

  // Span code to byte count: non-linear (code 2 is the widest)
  function automatic logic [3:0] spanBytes(input logic [1:0] code);
    logic [3:0] n;
    case (code)
      2'd0:    n = 4'd1;
      2'd1:    n = 4'd2;
      2'd2:    n = 4'd8;
      default: n = 4'd4;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/bkpt_slot_cmp.sv
module bkpt_slot_cmp
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PORT_W = 16,
  parameter int SIZE_W = 4
) (
  input  logic [ADDR_W-1:0] slotAddr,
  input  logic [1:0]        typeCode,
  input  logic [1:0]        lenCode,
  input  logic [ADDR_W-1:0] insnAddr,
  input  logic [ADDR_W-1:0] dataAddr,
  input  logic [SIZE_W-1:0] dataSize,
  input  logic              dataWrite,
  input  logic [PORT_W-1:0] portAddr,
  input  logic [SIZE_W-1:0] portSize,
  output logic              insnMatch,
  output logic              dataMatch,
  output logic              portMatch
);

  // Extra headroom so range ends never wrap
  localparam int EXT_W = ADDR_W + SIZE_W + 1;

  slotKind_e        kind;
  logic [EXT_W-1:0] slotLo, slotHi;
  logic [EXT_W-1:0] dataLo, dataHi;
  logic [EXT_W-1:0] portLo, portHi;
  logic             dataKindOk;
  logic             dataOverlap, portOverlap;

  assign kind = slotKind_e'(typeCode);

  always_comb begin
    slotLo = EXT_W'(slotAddr);
    slotHi = slotLo + EXT_W'(spanBytes(lenCode)) - EXT_W'(1);
    dataLo = EXT_W'(dataAddr);
    dataHi = dataLo + EXT_W'(dataSize) - EXT_W'(1);
    portLo = EXT_W'(portAddr);
    portHi = portLo + EXT_W'(portSize) - EXT_W'(1);
  end

  // Inclusive range overlap; zero-size accesses are excluded
  assign dataOverlap = (dataSize != '0) && (dataHi >= slotLo) && (dataLo <= slotHi);
  assign portOverlap = (portSize != '0) && (portHi >= slotLo) && (portLo <= slotHi);

  assign dataKindOk = (kind == KIND_ACCESS) || ((kind == KIND_WRITE) && dataWrite);

  assign insnMatch = (kind == KIND_INSN) && (insnAddr == slotAddr);
  assign dataMatch = dataKindOk && dataOverlap;
  assign portMatch = (kind == KIND_PORT) && portOverlap;

endmodule

// File: rtl/bkpt_match_dp.sv
module bkpt_match_dp
  import bkpt_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 32,
  parameter int PORT_W    = 16,
  parameter int SIZE_W    = 4,
  localparam int CTRL_W   = TYPE_BASE + FIELD_STRIDE * NUM_SLOTS
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [CTRL_W-1:0]           ctrlWord,
  input  logic [NUM_SLOTS*ADDR_W-1:0] slotAddrFlat,
  input  logic [ADDR_W-1:0]           insnAddr,
  input  logic [ADDR_W-1:0]           dataAddr,
  input  logic [SIZE_W-1:0]           dataSize,
  input  logic                        dataWrite,
  input  logic [PORT_W-1:0]           portAddr,
  input  logic [SIZE_W-1:0]           portSize,
  input  logic [ADDR_W-1:0]           portNextIp,
  input  ctrlStrobe_t                 strobes,
  output logic [NUM_SLOTS-1:0]        insnMask,
  output logic [NUM_SLOTS-1:0]        dataMask,
  output logic [NUM_SLOTS-1:0]        portMask,
  output logic [NUM_SLOTS-1:0]        enMask,
  output logic [NUM_SLOTS-1:0]        hitMask,
  output logic [NUM_SLOTS-1:0]        statusNibble,
  output logic                        dbgReq,
  output logic                        ipUpdValid,
  output logic [ADDR_W-1:0]           ipUpdValue
);

  logic [NUM_SLOTS-1:0] portRaw;
  logic [NUM_SLOTS-1:0] selMask;
  logic [NUM_SLOTS-1:0] hitMaskQ, statusQ;
  logic                 reqQ, ipValidQ;
  logic [ADDR_W-1:0]    ipValueQ;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    bkpt_slot_cmp #(
      .ADDR_W(ADDR_W),
      .PORT_W(PORT_W),
      .SIZE_W(SIZE_W)
    ) u_cmp (
      .slotAddr (slotAddrFlat[s*ADDR_W +: ADDR_W]),
      .typeCode (ctrlWord[TYPE_BASE + FIELD_STRIDE*s +: 2]),
      .lenCode  (ctrlWord[TYPE_BASE + FIELD_STRIDE*s + LEN_OFS +: 2]),
      .insnAddr (insnAddr),
      .dataAddr (dataAddr),
      .dataSize (dataSize),
      .dataWrite(dataWrite),
      .portAddr (portAddr),
      .portSize (portSize),
      .insnMatch(insnMask[s]),
      .dataMatch(dataMask[s]),
      .portMatch(portRaw[s])
    );
    // R1: local or global enable
    assign enMask[s] = ctrlWord[2*s] | ctrlWord[2*s+1];
  end

  // Port checks consider enabled slots only
  assign portMask = portRaw & enMask;

  if (2 * NUM_SLOTS < TYPE_BASE) begin : g_resv
    logic unusedResvBits;
    assign unusedResvBits = ^ctrlWord[TYPE_BASE-1:2*NUM_SLOTS];
  end

  always_comb begin
    unique case (strobes.src)
      SRC_INSN: selMask = insnMask;
      SRC_DATA: selMask = dataMask;
      SRC_PORT: selMask = portMask;
      default:  selMask = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitMaskQ <= '0;
      statusQ  <= '0;
      reqQ     <= 1'b0;
      ipValidQ <= 1'b0;
      ipValueQ <= '0;
    end else begin
      hitMaskQ <= selMask;
      reqQ     <= strobes.raise;
      ipValidQ <= strobes.advanceIp;
      if (strobes.writeStatus) statusQ <= selMask;
      if (strobes.advanceIp)   ipValueQ <= portNextIp;
    end
  end

  assign hitMask      = hitMaskQ;
  assign statusNibble = statusQ;
  assign dbgReq       = reqQ;
  assign ipUpdValid   = ipValidQ;
  assign ipUpdValue   = ipValueQ;

  // R6: a request always comes from a slot that was enabled at check time
  p_req_enabled_r6: assert property (@(posedge clk) disable iff (!rstN)
    dbgReq |-> ((hitMask & $past(enMask)) != '0));

  // R7: instruction-pointer update only travels with a request
  p_ip_with_req_r7: assert property (@(posedge clk) disable iff (!rstN)
    ipUpdValid |-> dbgReq);

  // R7: the update carries the next address presented with the port check
  p_ip_value_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.advanceIp |=> (ipUpdValue == $past(portNextIp)));

  // R7: a port hit mask never names a disabled slot
  p_port_enabled_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.src == SRC_PORT) |=> ((hitMask & ~$past(enMask)) == '0));

endmodule

// File: rtl/bkpt_match_ctl.sv
module bkpt_match_ctl
  import bkpt_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic                 insnValid,
  input  logic                 dataValid,
  input  logic                 portValid,
  input  logic [NUM_SLOTS-1:0] insnMask,
  input  logic [NUM_SLOTS-1:0] dataMask,
  input  logic [NUM_SLOTS-1:0] portMask,
  input  logic [NUM_SLOTS-1:0] enMask,
  output ctrlStrobe_t          strobes
);

  logic portHit, dataEnHit, insnEnHit;

  assign portHit   = |portMask;
  assign dataEnHit = |(dataMask & enMask);
  assign insnEnHit = |(insnMask & enMask);

  // R9: port over data over instruction
  always_comb begin
    strobes = '0;
    if (portValid) begin
      strobes.src         = SRC_PORT;
      strobes.writeStatus = portHit;
      strobes.raise       = portHit;
      strobes.advanceIp   = portHit;
    end else if (dataValid) begin
      strobes.src         = SRC_DATA;
      strobes.writeStatus = dataEnHit;
      strobes.raise       = dataEnHit;
    end else if (insnValid) begin
      strobes.src         = SRC_INSN;
      strobes.writeStatus = 1'b1;   // R4: forced status update
      strobes.raise       = insnEnHit;
    end
  end

endmodule

// File: rtl/bkpt_match_top.sv
module bkpt_match_top
  import bkpt_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 32,
  parameter int PORT_W    = 16,
  parameter int SIZE_W    = 4,
  localparam int CTRL_W   = TYPE_BASE + FIELD_STRIDE * NUM_SLOTS
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [CTRL_W-1:0]           ctrlWord,
  input  logic [NUM_SLOTS*ADDR_W-1:0] slotAddrFlat,
  input  logic                        insnValid,
  input  logic [ADDR_W-1:0]           insnAddr,
  input  logic                        dataValid,
  input  logic [ADDR_W-1:0]           dataAddr,
  input  logic [SIZE_W-1:0]           dataSize,
  input  logic                        dataWrite,
  input  logic                        portValid,
  input  logic [PORT_W-1:0]           portAddr,
  input  logic [SIZE_W-1:0]           portSize,
  input  logic [ADDR_W-1:0]           portNextIp,
  output logic [NUM_SLOTS-1:0]        hitMask,
  output logic [NUM_SLOTS-1:0]        statusNibble,
  output logic                        dbgReq,
  output logic                        ipUpdValid,
  output logic [ADDR_W-1:0]           ipUpdValue
);

  ctrlStrobe_t          strobes;
  logic [NUM_SLOTS-1:0] insnMask, dataMask, portMask, enMask;
  logic                 anyValid;

  assign anyValid = insnValid | dataValid | portValid;

  bkpt_match_dp #(
    .NUM_SLOTS(NUM_SLOTS),
    .ADDR_W   (ADDR_W),
    .PORT_W   (PORT_W),
    .SIZE_W   (SIZE_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrlWord    (ctrlWord),
    .slotAddrFlat(slotAddrFlat),
    .insnAddr    (insnAddr),
    .dataAddr    (dataAddr),
    .dataSize    (dataSize),
    .dataWrite   (dataWrite),
    .portAddr    (portAddr),
    .portSize    (portSize),
    .portNextIp  (portNextIp),
    .strobes     (strobes),
    .insnMask    (insnMask),
    .dataMask    (dataMask),
    .portMask    (portMask),
    .enMask      (enMask),
    .hitMask     (hitMask),
    .statusNibble(statusNibble),
    .dbgReq      (dbgReq),
    .ipUpdValid  (ipUpdValid),
    .ipUpdValue  (ipUpdValue)
  );

  bkpt_match_ctl #(
    .NUM_SLOTS(NUM_SLOTS)
  ) u_ctl (
    .insnValid(insnValid),
    .dataValid(dataValid),
    .portValid(portValid),
    .insnMask (insnMask),
    .dataMask (dataMask),
    .portMask (portMask),
    .enMask   (enMask),
    .strobes  (strobes)
  );

  // R8: an idle cycle clears the pulses and holds the status nibble
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !anyValid |=> (hitMask == '0 && !dbgReq && !ipUpdValid && $stable(statusNibble)));

  // R4: a lone instruction check always rewrites status with its mask
  p_insn_force_r4: assert property (@(posedge clk) disable iff (!rstN)
    (insnValid && !dataValid && !portValid) |=> (statusNibble == hitMask));

  // R11: outputs quiet while reset is held
  p_reset_quiet_r11: assert property (@(posedge clk)
    !rstN |=> (hitMask == '0 && statusNibble == '0 && !dbgReq && !ipUpdValid));

endmodule

// File: tb/bkpt_match_top_test.sv
`timescale 1ns/1ps
module bkpt_match_top_test;
  localparam int N  = 4;
  localparam int AW = 32;
  localparam int PW = 16;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [31:0]     ctrlWord = '0;
  logic [AW-1:0]   sa [N];
  logic [N*AW-1:0] slotAddrFlat;
  logic insnValid = 0, dataValid = 0, portValid = 0, dataWrite = 0;
  logic [AW-1:0] insnAddr = '0, dataAddr = '0, portNextIp = '0;
  logic [SW-1:0] dataSize = '0, portSize = '0;
  logic [PW-1:0] portAddr = '0;
  logic [N-1:0]  hitMask, statusNibble;
  logic dbgReq, ipUpdValid;
  logic [AW-1:0] ipUpdValue;

  always_comb
    for (int i = 0; i < N; i++) slotAddrFlat[i*AW +: AW] = sa[i];

  bkpt_match_top uut (
    .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord), .slotAddrFlat(slotAddrFlat),
    .insnValid(insnValid), .insnAddr(insnAddr),
    .dataValid(dataValid), .dataAddr(dataAddr), .dataSize(dataSize), .dataWrite(dataWrite),
    .portValid(portValid), .portAddr(portAddr), .portSize(portSize), .portNextIp(portNextIp),
    .hitMask(hitMask), .statusNibble(statusNibble), .dbgReq(dbgReq),
    .ipUpdValid(ipUpdValid), .ipUpdValue(ipUpdValue)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [N-1:0] expStatus = '0;

  function automatic logic [31:0] fld(int i, int ty, int ln);
    return (32'(ty) << (16 + 4*i)) | (32'(ln) << (18 + 4*i));
  endfunction

  function automatic int kindOf(int i);  return int'(ctrlWord[16+4*i +: 2]); endfunction
  function automatic bit enOf(int i);    return ctrlWord[2*i] | ctrlWord[2*i+1]; endfunction
  function automatic longint spanOf(int i);
    case (ctrlWord[18+4*i +: 2])
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 8;
      default: return 4;
    endcase
  endfunction
  function automatic bit overlaps(longint a, longint sz, int i);
    longint lo = longint'(sa[i]);
    if (sz == 0) return 0;
    return (a + sz - 1 >= lo) && (a <= lo + spanOf(i) - 1);
  endfunction

  task automatic runCycle(string tag, bit iv, logic [31:0] ip,
                          bit dv, logic [31:0] da, int ds, bit dw,
                          bit pv, int pa, int ps, logic [31:0] pn);
    logic [N-1:0] m = '0, enm = '0, newSt;
    bit wr = 0, rq = 0, adv = 0, ok;
    for (int i = 0; i < N; i++) enm[i] = enOf(i);
    if (pv) begin
      for (int i = 0; i < N; i++)
        m[i] = (kindOf(i) == 2) && enm[i] && overlaps(longint'(pa), longint'(ps), i);
      wr = (m != 0); rq = wr; adv = wr;
    end else if (dv) begin
      for (int i = 0; i < N; i++)
        m[i] = ((kindOf(i) == 3) || (kindOf(i) == 1 && dw)) && overlaps(longint'(da), longint'(ds), i);
      wr = ((m & enm) != 0); rq = wr;
    end else if (iv) begin
      for (int i = 0; i < N; i++) m[i] = (kindOf(i) == 0) && (sa[i] == ip);
      wr = 1; rq = ((m & enm) != 0);
    end
    newSt = wr ? m : expStatus;
    @(negedge clk);
    insnValid = iv; insnAddr = ip;
    dataValid = dv; dataAddr = da; dataSize = SW'(ds); dataWrite = dw;
    portValid = pv; portAddr = PW'(pa); portSize = SW'(ps); portNextIp = pn;
    @(negedge clk);
    ok = (hitMask == m) && (statusNibble == newSt) && (dbgReq == rq) &&
         (ipUpdValid == adv) && (!adv || ipUpdValue == pn);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: hit=%h st=%h req=%b ipv=%b ipval=%h expected hit=%h st=%h req=%b ipv=%b ipval=%h",
               tag, hitMask, statusNibble, dbgReq, ipUpdValid, ipUpdValue, m, newSt, rq, adv, pn);
    end
    insnValid = 0; dataValid = 0; portValid = 0;
    expStatus = newSt;
  endtask

  task automatic idleCheck(string tag);
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (hitMask != 0 || dbgReq || ipUpdValid || statusNibble != expStatus) begin
      fails++;
      $display("FAIL %s: hit=%h req=%b ipv=%b st=%h expected hit=0 req=0 ipv=0 st=%h",
               tag, hitMask, dbgReq, ipUpdValid, statusNibble, expStatus);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) sa[i] = '0;
    repeat (3) @(negedge clk);
    checks++;  // R11 reset state
    if (hitMask != 0 || statusNibble != 0 || dbgReq || ipUpdValid) begin
      fails++;
      $display("FAIL R11: hit=%h st=%h req=%b ipv=%b expected all zero", hitMask, statusNibble, dbgReq, ipUpdValid);
    end
    rstN = 1;
    idleCheck("R11 after release");

    // R3 / R2: each span code on a port slot, sweep single ports across its edges
    sa[1] = 32'h100;
    for (int lc = 0; lc < 4; lc++) begin
      ctrlWord = fld(1, 2, lc) | 32'h4;
      for (int p = 'hF8; p <= 'h10A; p++)
        runCycle("R3 span sweep", 0, 0, 0, 0, 0, 0, 1, p, 1, 32'h5000 + 32'(p));
    end

    // R7: port sizes 1..4 against a 4-byte slot with global enable
    sa[2] = 32'h300;
    ctrlWord = fld(2, 2, 3) | 32'h20;
    for (int sz = 1; sz <= 4; sz++)
      for (int p = 'h2FA; p <= 'h306; p++)
        runCycle("R7 port overlap", 0, 0, 0, 0, 0, 0, 1, p, sz, 32'hABC0_0000 + 32'(p));
    idleCheck("R8 idle after port");

    // R7 / R1: matching port slot with enables off never hits
    ctrlWord = fld(2, 2, 3);
    runCycle("R7 disabled port", 0, 0, 0, 0, 0, 0, 1, 'h300, 2, 32'h1234);

    // R5: read/write 8-byte slot and write-only 2-byte slot
    sa[0] = 32'h2000; sa[3] = 32'h2010;
    ctrlWord = fld(0, 3, 2) | fld(3, 1, 1) | 32'h1 | 32'h80;
    for (int a = 'h1FF8; a <= 'h2018; a++)
      for (int k = 0; k < 4; k++)
        for (int w = 0; w < 2; w++)
          runCycle("R5 data overlap", 0, 0, 1, 32'(a), 1 << k, w[0], 0, 0, 0, 0);

    // R6: four overlapping access slots under every enable pattern
    for (int i = 0; i < N; i++) sa[i] = 32'h4000 + 32'(i);
    for (int e = 0; e < 16; e++) begin
      ctrlWord = fld(0, 3, 0) | fld(1, 3, 1) | fld(2, 3, 3) | fld(3, 3, 2);
      for (int i = 0; i < N; i++) if (e[i]) ctrlWord |= 32'(1) << (2*i + (i % 2));
      runCycle("R6 enable pattern", 0, 0, 1, 32'h4002, 1, 0, 0, 0, 0, 0);
      idleCheck("R8 idle hold");
    end

    // R10: zero size never matches
    ctrlWord = fld(0, 3, 2) | fld(1, 2, 2) | 32'hF;
    sa[0] = 32'h50; sa[1] = 32'h50;
    runCycle("R10 zero data", 0, 0, 1, 32'h50, 0, 1, 0, 0, 0, 0);
    runCycle("R10 zero port", 0, 0, 0, 0, 0, 0, 1, 'h50, 0, 32'h77);

    // R1 / R4: instruction slots under each local/global combination
    for (int i = 0; i < N; i++) sa[i] = 32'h8000 + 32'(i * 16);
    for (int e = 0; e < 4; e++) begin
      ctrlWord = fld(0, 0, 0) | fld(1, 0, 2) | fld(2, 0, 3) | fld(3, 2, 0);
      for (int i = 0; i < N; i++) ctrlWord |= 32'(e) << (2*i);
      for (int i = 0; i < N; i++)
        for (int d = -1; d <= 1; d++)
          runCycle("R1 R4 insn match", 1, sa[i] + 32'(d), 0, 0, 0, 0, 0, 0, 0, 0);
    end

    // R4: disabled match still forces the status update
    ctrlWord = fld(0, 0, 0) | fld(1, 0, 0) | 32'h4;
    sa[0] = 32'h9000; sa[1] = 32'h9000;
    runCycle("R4 forced status", 1, 32'h9000, 0, 0, 0, 0, 0, 0, 0, 0);
    runCycle("R4 no match clears", 1, 32'h9004, 0, 0, 0, 0, 0, 0, 0, 0);

    // R9: simultaneous checks, port beats data beats instruction
    ctrlWord = fld(0, 0, 0) | fld(1, 3, 3) | fld(2, 2, 0) | 32'h15;
    sa[0] = 32'hA000; sa[1] = 32'hB000; sa[2] = 32'h60;
    runCycle("R9 all three", 1, 32'hA000, 1, 32'hB000, 4, 0, 1, 'h60, 1, 32'hC0DE);
    runCycle("R9 port miss", 1, 32'hA000, 1, 32'hB000, 4, 0, 1, 'h70, 1, 32'hC0DE);
    runCycle("R9 data over insn", 1, 32'hA000, 1, 32'hB002, 1, 1, 0, 0, 0, 0);
    runCycle("R9 data miss", 1, 32'hA000, 1, 32'hC000, 1, 1, 0, 0, 0, 0);
    idleCheck("R8 final idle");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule